// File: doc/BRIEF.md
# Segment Base-Limit Translation Unit

This unit turns a program offset into a linear address through one of six segment descriptors: code, stack, data, extra and two general-purpose descriptors. Each descriptor holds a base, a limit and four permission bits. The bits grant read, write and execute, and a fourth bit allows user-mode access. The access kind picks the descriptor. An instruction fetch always goes through the code descriptor and a stack access always goes through the stack descriptor. A data access goes through the data descriptor unless an explicit override names another one.

In one combinational step the unit reads the descriptor, adds the base to the offset, compares the offset against the limit and checks the permissions. The result is registered and appears one cycle later. It is either a linear address or a fault with a reason code. A separate load port writes a complete descriptor into a chosen slot.

Top module: `seg_xlate`

## Requirements
- R1: For an accepted request, `rspValid` rises on the following clock edge. With no fault, `rspLinear` equals the descriptor base plus the zero-extended offset, modulo 2^ADDR_W.
- R2: An offset greater than or equal to the descriptor limit faults with `rspReason` = 2'b01 and `rspLinear` = 0.
- R3: Access kind 2'b00 (fetch) uses descriptor 0 (code) and requires its execute bit. Any override is ignored.
- R4: Access kind 2'b01 (stack) uses descriptor 1 (stack). Any override is ignored.
- R5: Access kinds 2'b10 and 2'b11 (data) use descriptor 2 (data). With `ovrValid` high and `ovrSeg` in 0..5, they use descriptor `ovrSeg` instead. Override values 6 and 7 fall back to descriptor 2.
- R6: A request faults with `rspReason` = 2'b10 and `rspLinear` = 0 in any of these cases: a stack or data read lacks the read bit; a stack or data write lacks the write bit; a fetch lacks the execute bit; a user-mode request (`reqUser` = 1) hits a descriptor whose user bit is clear.
- R7: When the limit check and the permission check both fail, the reason is 2'b01.
- R8: After reset, all outputs are 0 and every descriptor has base 0, limit 2^OFS_W and all four permission bits set, so every access translates to the offset unchanged.
- R9: A descriptor load becomes visible to requests made on the cycle after the load. A request made in the same cycle as the load sees the old descriptor. A load to slot 6 or 7 changes nothing.
- R10: A cycle without a request yields `rspValid` = 0 and `rspFault` = 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request |
| reqKind | input | 2 | Access kind: 0 fetch, 1 stack, 2/3 data |
| reqWrite | input | 1 | Access is a write (stack/data) |
| reqUser | input | 1 | Access is made in user mode |
| ovrValid | input | 1 | Explicit segment override present |
| ovrSeg | input | 3 | Override descriptor index |
| reqOffset | input | OFS_W | Program offset |
| ldValid | input | 1 | Descriptor load strobe |
| ldSeg | input | 3 | Descriptor slot to load |
| ldBase | input | ADDR_W | New base |
| ldLimit | input | OFS_W+1 | New limit (exclusive) |
| ldRead | input | 1 | New read permission |
| ldWrite | input | 1 | New write permission |
| ldExec | input | 1 | New execute permission |
| ldUser | input | 1 | New user-access permission |
| rspValid | output | 1 | Registered result valid |
| rspFault | output | 1 | Result is a fault |
| rspReason | output | 2 | 0 none, 1 limit, 2 permission |
| rspLinear | output | ADDR_W | Linear address (0 on fault) |

## Verification
The bench builds the unit with OFS_W = 6 and ADDR_W = 8. At these widths every offset can be swept against every descriptor, every access kind, every override code, read and write, and user and kernel mode. The expected address, fault and reason come from a small arithmetic model. The narrow address also lets a large base plus an offset wrap, and a limit of 0 or of 2^6 covers both ends of the limit range. With the same configuration, a load and a request can be driven in the same cycle to observe the old-descriptor rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEG_COUNT = 6;
  localparam int SEG_IDX_W = 3;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_STACK = 2'd1;

  localparam logic [SEG_IDX_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEG_IDX_W-1:0] SEG_STACK = 3'd1;
  localparam logic [SEG_IDX_W-1:0] SEG_DATA  = 3'd2;

  localparam logic [1:0] REASON_NONE  = 2'b00;
  localparam logic [1:0] REASON_LIMIT = 2'b01;
  localparam logic [1:0] REASON_PERM  = 2'b10;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic usr;
  } segPerm_t;

  typedef struct packed {
    logic                 capture;
    logic [SEG_IDX_W-1:0] segSel;
    logic                 needRead;
    logic                 needWrite;
    logic                 needExec;
    logic                 userMode;
  } xlateStrobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic                 reqWrite,
  input  logic                 reqUser,
  input  logic                 ovrValid,
  input  logic [SEG_IDX_W-1:0] ovrSeg,
  output xlateStrobe_t         strb
);

  logic ovrUsable;
  assign ovrUsable = ovrValid && (ovrSeg < SEG_IDX_W'(SEG_COUNT));

  always_comb begin
    strb          = '0;
    strb.capture  = reqValid;
    strb.userMode = reqUser;
    case (reqKind)
      KIND_FETCH: begin
        strb.segSel   = SEG_CODE;
        strb.needExec = 1'b1;
      end
      KIND_STACK: begin
        strb.segSel    = SEG_STACK;
        strb.needWrite = reqWrite;
        strb.needRead  = !reqWrite;
      end
      default: begin
        strb.segSel    = ovrUsable ? ovrSeg : SEG_DATA;
        strb.needWrite = reqWrite;
        strb.needRead  = !reqWrite;
      end
    endcase
  end

endmodule

// File: rtl/seg_xlate_descfile.sv
module seg_xlate_descfile
  import seg_xlate_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ldValid,
  input  logic [SEG_IDX_W-1:0] ldSeg,
  input  logic [ADDR_W-1:0]    ldBase,
  input  logic [OFS_W:0]       ldLimit,
  input  segPerm_t             ldPerm,
  input  logic [SEG_IDX_W-1:0] rdSel,
  output logic [ADDR_W-1:0]    rdBase,
  output logic [OFS_W:0]       rdLimit,
  output segPerm_t             rdPerm
);

  localparam int LIM_W = OFS_W + 1;
  localparam logic [LIM_W-1:0] LIMIT_OPEN = LIM_W'(1) << OFS_W;

  logic [ADDR_W-1:0] baseQ  [SEG_COUNT];
  logic [LIM_W-1:0]  limitQ [SEG_COUNT];
  segPerm_t          permQ  [SEG_COUNT];

  for (genvar gi = 0; gi < SEG_COUNT; gi++) begin : g_slot
    logic slotWe;
    assign slotWe = ldValid && (ldSeg == SEG_IDX_W'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[gi]  <= '0;
        limitQ[gi] <= LIMIT_OPEN;
        permQ[gi]  <= '1;
      end else if (slotWe) begin
        baseQ[gi]  <= ldBase;
        limitQ[gi] <= ldLimit;
        permQ[gi]  <= ldPerm;
      end
    end
  end

  always_comb begin
    rdBase  = baseQ[SEG_DATA];
    rdLimit = limitQ[SEG_DATA];
    rdPerm  = permQ[SEG_DATA];
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (rdSel == SEG_IDX_W'(i)) begin
        rdBase  = baseQ[i];
        rdLimit = limitQ[i];
        rdPerm  = permQ[i];
      end
    end
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xlateStrobe_t         strb,
  input  logic [OFS_W-1:0]     reqOffset,
  input  logic                 ldValid,
  input  logic [SEG_IDX_W-1:0] ldSeg,
  input  logic [ADDR_W-1:0]    ldBase,
  input  logic [OFS_W:0]       ldLimit,
  input  segPerm_t             ldPerm,
  output logic                 rspValid,
  output logic                 rspFault,
  output logic [1:0]           rspReason,
  output logic [ADDR_W-1:0]    rspLinear
);

  logic [ADDR_W-1:0] selBase;
  logic [OFS_W:0]    selLimit;
  segPerm_t          selPerm;

  seg_xlate_descfile #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_desc (
    .clk     (clk),
    .rstN    (rstN),
    .ldValid (ldValid),
    .ldSeg   (ldSeg),
    .ldBase  (ldBase),
    .ldLimit (ldLimit),
    .ldPerm  (ldPerm),
    .rdSel   (strb.segSel),
    .rdBase  (selBase),
    .rdLimit (selLimit),
    .rdPerm  (selPerm)
  );

  logic [ADDR_W-1:0] sumAddr;
  logic              limitHit;
  logic              permHit;
  logic              anyFault;
  logic [1:0]        reasonNext;

  assign sumAddr  = selBase + ADDR_W'(reqOffset);
  assign limitHit = {1'b0, reqOffset} >= selLimit;
  assign permHit  = (strb.needRead  && !selPerm.rd) ||
                    (strb.needWrite && !selPerm.wr) ||
                    (strb.needExec  && !selPerm.ex) ||
                    (strb.userMode  && !selPerm.usr);
  assign anyFault = limitHit || permHit;

  always_comb begin
    if (limitHit)     reasonNext = REASON_LIMIT;
    else if (permHit) reasonNext = REASON_PERM;
    else              reasonNext = REASON_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= 1'b0;
      rspReason <= REASON_NONE;
      rspLinear <= '0;
    end else begin
      rspValid  <= strb.capture;
      rspFault  <= strb.capture && anyFault;
      rspReason <= strb.capture ? reasonNext : REASON_NONE;
      rspLinear <= (strb.capture && !anyFault) ? sumAddr : '0;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              ovrValid,
  input  logic [2:0]        ovrSeg,
  input  logic [OFS_W-1:0]  reqOffset,
  input  logic              ldValid,
  input  logic [2:0]        ldSeg,
  input  logic [ADDR_W-1:0] ldBase,
  input  logic [OFS_W:0]    ldLimit,
  input  logic              ldRead,
  input  logic              ldWrite,
  input  logic              ldExec,
  input  logic              ldUser,
  output logic              rspValid,
  output logic              rspFault,
  output logic [1:0]        rspReason,
  output logic [ADDR_W-1:0] rspLinear
);

  xlateStrobe_t strb;
  segPerm_t     ldPerm;

  assign ldPerm = '{rd: ldRead, wr: ldWrite, ex: ldExec, usr: ldUser};

  seg_xlate_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqWrite (reqWrite),
    .reqUser  (reqUser),
    .ovrValid (ovrValid),
    .ovrSeg   (ovrSeg),
    .strb     (strb)
  );

  seg_xlate_dp #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqOffset (reqOffset),
    .ldValid   (ldValid),
    .ldSeg     (ldSeg),
    .ldBase    (ldBase),
    .ldLimit   (ldLimit),
    .ldPerm    (ldPerm),
    .rspValid  (rspValid),
    .rspFault  (rspFault),
    .rspReason (rspReason),
    .rspLinear (rspLinear)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              rspValid,
  input logic              rspFault,
  input logic [1:0]        rspReason,
  input logic [ADDR_W-1:0] rspLinear
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspFault));

  // R2
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspLinear == '0 && rspReason != 2'b00 && rspReason != 2'b11));

  // R6
  clean_reason_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspReason == 2'b00);

  // R10
  fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> rspValid);

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .rspValid  (rspValid),
  .rspFault  (rspFault),
  .rspReason (rspReason),
  .rspLinear (rspLinear)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

  localparam int OW   = 6;
  localparam int AW   = 8;
  localparam int NSEG = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqKind = '0;
  logic          reqWrite = 1'b0;
  logic          reqUser = 1'b0;
  logic          ovrValid = 1'b0;
  logic [2:0]    ovrSeg = '0;
  logic [OW-1:0] reqOffset = '0;
  logic          ldValid = 1'b0;
  logic [2:0]    ldSeg = '0;
  logic [AW-1:0] ldBase = '0;
  logic [OW:0]   ldLimit = '0;
  logic          ldRead = 1'b0;
  logic          ldWrite = 1'b0;
  logic          ldExec = 1'b0;
  logic          ldUser = 1'b0;
  logic          rspValid;
  logic          rspFault;
  logic [1:0]    rspReason;
  logic [AW-1:0] rspLinear;

  always #10 clk = ~clk;

  seg_xlate #(.OFS_W(OW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqWrite(reqWrite), .reqUser(reqUser), .ovrValid(ovrValid), .ovrSeg(ovrSeg),
    .reqOffset(reqOffset), .ldValid(ldValid), .ldSeg(ldSeg), .ldBase(ldBase),
    .ldLimit(ldLimit), .ldRead(ldRead), .ldWrite(ldWrite), .ldExec(ldExec),
    .ldUser(ldUser), .rspValid(rspValid), .rspFault(rspFault),
    .rspReason(rspReason), .rspLinear(rspLinear)
  );

  // model: perm bits {rd, wr, ex, usr}
  logic [AW-1:0] mBase [NSEG];
  logic [OW:0]   mLim  [NSEG];
  logic [3:0]    mPerm [NSEG];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic compare(string tag, logic v, logic f, logic [1:0] r, logic [AW-1:0] a);
    nChecks++;
    if (rspValid !== v || rspFault !== f || rspReason !== r || rspLinear !== a) begin
      nFails++;
      $display("FAIL %s: got v=%0b f=%0b r=%0d a=%0h, expected v=%0b f=%0b r=%0d a=%0h",
               tag, rspValid, rspFault, rspReason, rspLinear, v, f, r, a);
    end
  endtask

  task automatic expectFor(int kind, bit wr, bit usr, bit ov, int os, int off,
                           output logic f, output logic [1:0] r, output logic [AW-1:0] a);
    int  seg;
    bit  limF, permF, need;
    if (kind == 0)                 seg = 0;
    else if (kind == 1)            seg = 1;
    else if (ov && os < NSEG)      seg = os;
    else                           seg = 2;
    limF = (off >= int'(mLim[seg]));
    if (kind == 0) need = mPerm[seg][1];
    else           need = wr ? mPerm[seg][2] : mPerm[seg][3];
    permF = !need || (usr && !mPerm[seg][0]);
    f = limF || permF;
    r = limF ? 2'd1 : (permF ? 2'd2 : 2'd0);
    a = f ? '0 : AW'(int'(mBase[seg]) + off);
  endtask

  task automatic driveReq(int kind, bit wr, bit usr, bit ov, int os, int off);
    reqValid  = 1'b1;
    reqKind   = 2'(kind);
    reqWrite  = wr;
    reqUser   = usr;
    ovrValid  = ov;
    ovrSeg    = 3'(os);
    reqOffset = OW'(off);
  endtask

  task automatic driveLd(int seg, int base, int lim, logic [3:0] perm);
    ldValid = 1'b1;
    ldSeg   = 3'(seg);
    ldBase  = AW'(base);
    ldLimit = (OW+1)'(lim);
    {ldRead, ldWrite, ldExec, ldUser} = perm;
  endtask

  task automatic modelLd(int seg, int base, int lim, logic [3:0] perm);
    if (seg < NSEG) begin
      mBase[seg] = AW'(base);
      mLim[seg]  = (OW+1)'(lim);
      mPerm[seg] = perm;
    end
  endtask

  task automatic doLoad(int seg, int base, int lim, logic [3:0] perm);
    @(negedge clk);
    driveLd(seg, base, lim, perm);
    @(posedge clk);
    #1;
    ldValid = 1'b0;
    modelLd(seg, base, lim, perm);
  endtask

  task automatic doXlate(string tag, int kind, bit wr, bit usr, bit ov, int os, int off);
    logic f; logic [1:0] r; logic [AW-1:0] a;
    @(negedge clk);
    driveReq(kind, wr, usr, ov, os, off);
    @(posedge clk);
    #1;
    expectFor(kind, wr, usr, ov, os, off, f, r, a);
    compare(tag, 1'b1, f, r, a);
    reqValid = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < NSEG; s++) begin
      mBase[s] = '0; mLim[s] = (OW+1)'(1 << OW); mPerm[s] = 4'b1111;
    end
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs idle in and right after reset
    compare("R8 reset outputs", 1'b0, 1'b0, 2'd0, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    compare("R8 after release", 1'b0, 1'b0, 2'd0, '0);

    // R8: identity translation at reset, every descriptor via override
    for (int os = 0; os < NSEG; os++)
      for (int off = 0; off < (1 << OW); off++) begin
        doXlate("R8 identity", 2, off[0], 1'b1, 1'b1, os, off);
        nChecks++;
        if (rspLinear !== AW'(off)) begin
          nFails++;
          $display("FAIL R8 identity: got %0h expected %0h", rspLinear, off);
        end
      end

    // descriptor setup
    doLoad(0, 8'h40, 40, 4'b0011);
    doLoad(1, 8'hF0, 50, 4'b1101);
    doLoad(2, 8'h10, 64, 4'b1100);
    doLoad(3, 8'h80, 20, 4'b1001);
    doLoad(4, 8'hC8, 63, 4'b0110);
    doLoad(5, 8'h05,  0, 4'b0000);
    // R9: load to slot 6 must change nothing (sweep below uses untouched model)
    doLoad(6, 8'hAA, 3, 4'b0000);
    doLoad(7, 8'h55, 1, 4'b0000);

    // sweep: every offset, kind, override, direction and mode
    for (int off = 0; off < (1 << OW); off++)
      for (int m = 0; m < 4; m++) begin
        doXlate("R3 fetch via code", 0, m[0], m[1], 1'b1, 3, off);
        doXlate("R4 stack via stack", 1, m[0], m[1], 1'b1, 4, off);
        doXlate("R5 data default", 2, m[0], m[1], 1'b0, 5, off);
        for (int os = 0; os < 8; os++)
          doXlate("R5 data override", 3, m[0], m[1], 1'b1, os, off);
      end

    // R1: wrap modulo 2^ADDR_W (0xF0 + 0x20 = 0x10)
    doXlate("R1 wrap", 1, 1'b0, 1'b0, 1'b0, 0, 32);
    nChecks++;
    if (rspLinear !== 8'h10) begin
      nFails++; $display("FAIL R1 wrap: got %0h expected 10", rspLinear);
    end
    // R2: offset equal to limit faults
    doXlate("R2 at limit", 0, 1'b0, 1'b0, 1'b0, 0, 40);
    nChecks++;
    if (rspReason !== 2'd1) begin
      nFails++; $display("FAIL R2 at limit: got %0d expected 1", rspReason);
    end
    // R6: write to read-only descriptor
    doXlate("R6 read-only write", 2, 1'b1, 1'b0, 1'b1, 3, 0);
    nChecks++;
    if (rspReason !== 2'd2) begin
      nFails++; $display("FAIL R6 perm: got %0d expected 2", rspReason);
    end
    // R7: limit and permission both fail -> limit reason
    doXlate("R7 priority", 2, 1'b1, 1'b1, 1'b1, 3, 20);
    nChecks++;
    if (rspReason !== 2'd1) begin
      nFails++; $display("FAIL R7 priority: got %0d expected 1", rspReason);
    end

    // R9: same-cycle load and request sees old descriptor
    begin
      logic f; logic [1:0] r; logic [AW-1:0] a;
      @(negedge clk);
      driveLd(2, 8'h33, 64, 4'b1111);
      driveReq(2, 1'b0, 1'b0, 1'b0, 0, 5);
      @(posedge clk);
      #1;
      expectFor(2, 1'b0, 1'b0, 1'b0, 0, 5, f, r, a);
      compare("R9 same-cycle old value", 1'b1, f, r, a);
      ldValid = 1'b0;
      reqValid = 1'b0;
      modelLd(2, 8'h33, 64, 4'b1111);
    end
    doXlate("R9 next-cycle new value", 2, 1'b0, 1'b0, 1'b0, 0, 5);
    nChecks++;
    if (rspLinear !== 8'h38) begin
      nFails++; $display("FAIL R9 new value: got %0h expected 38", rspLinear);
    end

    // R10: idle cycle gives no response
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    compare("R10 idle", 1'b0, 1'b0, 2'd0, '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule